// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block turns a small bank of timing registers into the horizontal and vertical scan of a display. Two chained counters walk the pixel position across each line and down each frame. Comparators against the programmed boundaries produce a data-enable window, an hsync pulse, a vsync pulse, an early line-fetch strobe and an embedded composite sync flag. Every boundary register holds the boundary position minus one. For example, a line of N pixels is programmed as N-1. The sync pulse of an axis covers the positions strictly after its start value, up to and including its end value.

Software writes the registers over a write-only register bus, one register per cycle. A write is visible from the next clock edge. The usual sequence is: clear the control register, load the timing, then set the enable bit and the refresh bit again. A sync-control register inverts either sync, silences either sync, or silences both. A display-control register blanks the video while the syncs keep running. After reset the timing registers describe a 1280x1024 mode: horizontal front porch 48, sync 112, back porch 248; vertical front porch 1, sync 3, back porch 38. The reset fetch point sits 88 pixels before the end of the line.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the control register is zero. Both counters read zero and de, hsync, vsync, the fetch strobe and the embedded sync all read 0.
- R2: The reset timing is the 1280x1024 mode described above, in the minus-one form: totals 1687/1065, active 1279/1023, sync start 1327/1024, sync end 1439/1027, fetch point 1599.
- R3: While enabled, x advances by one every clock. When x has reached the horizontal total, x returns to 0 on the next clock and y advances. When y is also at the vertical total, y returns to 0.
- R4: de is high only when enabled, refresh is set, display-off is clear, x <= active width value and y <= active height value.
- R5: hsync is active when start < x <= end; vsync is active when start < y <= end. Both are active-high by default.
- R6: Sync-control bit 3 inverts hsync and bit 4 inverts vsync. Each bit also sets the inactive level of its sync.
- R7: Sync-control bit 5 holds hsync at its inactive level, bit 6 does the same for vsync, and bit 1 does it for both.
- R8: Display-control bit 1 forces de low while x, y and the syncs keep running.
- R9: The fetch strobe is high for the one clock in which x equals the fetch-point register while enabled.
- R10: While control bit 0 (enable) is clear, de, the fetch strobe and the embedded sync are low and both syncs sit at their inactive level. From one clock after the enable bit clears, x and y read zero.
- R11: Control bit 1 (refresh) clear keeps de low while the counters, the syncs and the fetch strobe run.
- R12: The embedded sync output is high when sync-control bit 0 is set and either gated sync is active (that is, before inversion).
- R13: Register addresses are: 0 control, 1 h total, 2 h active, 3 hsync start, 4 hsync end, 5 v total, 6 v active, 7 vsync start, 8 vsync end, 9 fetch point, 10 sync control, 11 display control. A write takes effect at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register address |
| reg_wr_data | input | 12 | Register write data |
| pix_x_o | output | 12 | Horizontal pixel position |
| pix_y_o | output | 12 | Vertical line position |
| de_o | output | 1 | Active video window |
| hsync_o | output | 1 | Horizontal sync after gating and polarity |
| vsync_o | output | 1 | Vertical sync after gating and polarity |
| fetch_o | output | 1 | Early line-fetch strobe |
| sync_embed_o | output | 1 | Composite sync for embedding on video |

## Verification
The counters are the only timing registers. Every other output is combinational from the counters and the register bank. So a register write sampled at edge P is visible at the falling edge that follows P. After an enable write at P, that falling edge shows position (0,0), and each later falling edge shows the next position. After a disable write, the gating of de, the syncs and the strobe applies at once, while the counters need one more edge before they read zero; the bench waits one extra edge before it queues zero positions. The driver queues one expected record per cycle, computed from the requirement formulas, right after the edge it depends on. The monitor pops and compares one record at each falling edge.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int COORD_W = 12;
    localparam int DATA_W  = COORD_W;
    localparam int ADDR_W  = 4;
    localparam int AXES    = 2;

    typedef logic [COORD_W-1:0] coord_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL     = 4'd0,
        RA_H_TOTAL  = 4'd1,
        RA_H_ACT    = 4'd2,
        RA_HS_BEG   = 4'd3,
        RA_HS_END   = 4'd4,
        RA_V_TOTAL  = 4'd5,
        RA_V_ACT    = 4'd6,
        RA_VS_BEG   = 4'd7,
        RA_VS_END   = 4'd8,
        RA_FETCH    = 4'd9,
        RA_SYNC     = 4'd10,
        RA_DISP     = 4'd11
    } reg_addr_e;

    // control register bit positions
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_RF_BIT   = 1;
    // sync control bit positions
    localparam int SY_EMBED_BIT = 0;
    localparam int SY_ALL_BIT   = 1;
    localparam int SY_HINV_BIT  = 3;
    localparam int SY_VINV_BIT  = 4;
    localparam int SY_HOFF_BIT  = 5;
    localparam int SY_VOFF_BIT  = 6;
    // display control bit position
    localparam int DISP_OFF_BIT = 1;

    typedef struct packed {
        coord_t total;
        coord_t active;
        coord_t sync_beg;
        coord_t sync_end;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t h;
        axis_cfg_t v;
        coord_t    fetch_at;
    } timing_cfg_t;

    typedef struct packed {
        logic enable;
        logic refresh;
    } ctl_t;

    typedef struct packed {
        logic vs_off;
        logic hs_off;
        logic vs_inv;
        logic hs_inv;
        logic all_off;
        logic embed;
    } sync_ctl_t;

    typedef struct packed {
        logic in_active;
        logic in_sync;
    } axis_flags_t;

    // reset mode, given in visible pixels and porches
    localparam int DEF_H_ACT   = 1280;
    localparam int DEF_H_FP    = 48;
    localparam int DEF_H_SYNC  = 112;
    localparam int DEF_H_BP    = 248;
    localparam int DEF_V_ACT   = 1024;
    localparam int DEF_V_FP    = 1;
    localparam int DEF_V_SYNC  = 3;
    localparam int DEF_V_BP    = 38;
    localparam int DEF_PREFETCH = 88;

    function automatic axis_cfg_t axis_from_porches(input int act, input int fp,
                                                    input int sw, input int bp);
        axis_cfg_t a;
        a.total    = coord_t'(act + fp + sw + bp - 1);
        a.active   = coord_t'(act - 1);
        a.sync_beg = coord_t'(act + fp - 1);
        a.sync_end = coord_t'(act + fp + sw - 1);
        return a;
    endfunction

    function automatic timing_cfg_t default_timing();
        timing_cfg_t t;
        int htot;
        int pre;
        htot = DEF_H_ACT + DEF_H_FP + DEF_H_SYNC + DEF_H_BP;
        pre  = (DEF_PREFETCH >= htot) ? htot - 1 : DEF_PREFETCH;
        t.h  = axis_from_porches(DEF_H_ACT, DEF_H_FP, DEF_H_SYNC, DEF_H_BP);
        t.v  = axis_from_porches(DEF_V_ACT, DEF_V_FP, DEF_V_SYNC, DEF_V_BP);
        t.fetch_at = coord_t'(htot - pre - 1);
        return t;
    endfunction

    function automatic sync_ctl_t unpack_sync(input logic [DATA_W-1:0] d);
        sync_ctl_t s;
        s.embed   = d[SY_EMBED_BIT];
        s.all_off = d[SY_ALL_BIT];
        s.hs_inv  = d[SY_HINV_BIT];
        s.vs_inv  = d[SY_VINV_BIT];
        s.hs_off  = d[SY_HOFF_BIT];
        s.vs_off  = d[SY_VOFF_BIT];
        return s;
    endfunction

endpackage

// File: rtl/rtg_regbank.sv
module rtg_regbank
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output timing_cfg_t       cfg,
    output ctl_t              ctl,
    output sync_ctl_t         sync_ctl,
    output logic              disp_off
);

    localparam timing_cfg_t RESET_CFG = default_timing();

    coord_t wr_coord;
    assign wr_coord = wr_data[COORD_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= RESET_CFG;
            ctl      <= '0;
            sync_ctl <= '0;
            disp_off <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_CTRL: begin
                    ctl.enable  <= wr_data[CTL_EN_BIT];
                    ctl.refresh <= wr_data[CTL_RF_BIT];
                end
                RA_H_TOTAL: cfg.h.total    <= wr_coord;
                RA_H_ACT:   cfg.h.active   <= wr_coord;
                RA_HS_BEG:  cfg.h.sync_beg <= wr_coord;
                RA_HS_END:  cfg.h.sync_end <= wr_coord;
                RA_V_TOTAL: cfg.v.total    <= wr_coord;
                RA_V_ACT:   cfg.v.active   <= wr_coord;
                RA_VS_BEG:  cfg.v.sync_beg <= wr_coord;
                RA_VS_END:  cfg.v.sync_end <= wr_coord;
                RA_FETCH:   cfg.fetch_at   <= wr_coord;
                RA_SYNC:    sync_ctl       <= unpack_sync(wr_data);
                RA_DISP:    disp_off       <= wr_data[DISP_OFF_BIT];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rtg_axis_counter.sv
module rtg_axis_counter
    import rtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   step,
    input  coord_t limit,
    output coord_t pos,
    output logic   at_end
);

    // at or past the limit counts as the end, so a shortened total
    // written while running still wraps on the next step
    assign at_end = (pos >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos <= '0;
        end else if (step) begin
            pos <= at_end ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/rtg_axis_window.sv
module rtg_axis_window
    import rtg_pkg::*;
(
    input  coord_t      pos,
    input  axis_cfg_t   acfg,
    output axis_flags_t flags
);

    always_comb begin
        flags.in_active = (pos <= acfg.active);
        flags.in_sync   = (pos > acfg.sync_beg) && (pos <= acfg.sync_end);
    end

endmodule

// File: rtl/rtg_output_stage.sv
module rtg_output_stage
    import rtg_pkg::*;
(
    input  logic        run,
    input  logic        refresh,
    input  logic        disp_off,
    input  sync_ctl_t   sync_ctl,
    input  axis_flags_t h_flags,
    input  axis_flags_t v_flags,
    input  logic        fetch_hit,
    output logic        de,
    output logic        hsync,
    output logic        vsync,
    output logic        fetch,
    output logic        embed
);

    logic hs_gated;
    logic vs_gated;

    always_comb begin
        hs_gated = run && h_flags.in_sync && !sync_ctl.hs_off && !sync_ctl.all_off;
        vs_gated = run && v_flags.in_sync && !sync_ctl.vs_off && !sync_ctl.all_off;
        hsync    = hs_gated ^ sync_ctl.hs_inv;
        vsync    = vs_gated ^ sync_ctl.vs_inv;
        embed    = sync_ctl.embed && (hs_gated || vs_gated);
        de       = run && refresh && !disp_off && h_flags.in_active && v_flags.in_active;
        fetch    = run && fetch_hit;
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [COORD_W-1:0] pix_x_o,
    output logic [COORD_W-1:0] pix_y_o,
    output logic              de_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              fetch_o,
    output logic              sync_embed_o
);

    timing_cfg_t cfg;
    ctl_t        ctl;
    sync_ctl_t   sync_ctl;
    logic        disp_off;

    rtg_regbank u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .cfg      (cfg),
        .ctl      (ctl),
        .sync_ctl (sync_ctl),
        .disp_off (disp_off)
    );

    axis_cfg_t   acfg  [AXES];
    coord_t      pos   [AXES];
    logic        wrap  [AXES];
    axis_flags_t flags [AXES];

    assign acfg[0] = cfg.h;
    assign acfg[1] = cfg.v;

    // axis 0 steps every clock; each later axis steps when the one before wraps
    for (genvar a = 0; a < AXES; a++) begin : g_axis
        logic step;
        if (a == 0) begin : g_first
            assign step = 1'b1;
        end else begin : g_chained
            assign step = wrap[a-1];
        end

        rtg_axis_counter u_cnt (
            .clk    (clk),
            .rst    (rst),
            .run    (ctl.enable),
            .step   (step),
            .limit  (acfg[a].total),
            .pos    (pos[a]),
            .at_end (wrap[a])
        );

        rtg_axis_window u_win (
            .pos   (pos[a]),
            .acfg  (acfg[a]),
            .flags (flags[a])
        );
    end

    rtg_output_stage u_out (
        .run       (ctl.enable),
        .refresh   (ctl.refresh),
        .disp_off  (disp_off),
        .sync_ctl  (sync_ctl),
        .h_flags   (flags[0]),
        .v_flags   (flags[1]),
        .fetch_hit (pos[0] == cfg.fetch_at),
        .de        (de_o),
        .hsync     (hsync_o),
        .vsync     (vsync_o),
        .fetch     (fetch_o),
        .embed     (sync_embed_o)
    );

    assign pix_x_o = pos[0];
    assign pix_y_o = pos[1];

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
    import rtg_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   run,
    input coord_t h_total,
    input coord_t h_act,
    input coord_t v_act,
    input coord_t fetch_at,
    input logic   hs_off,
    input logic   all_off,
    input logic   hs_inv,
    input logic   disp_off,
    input coord_t x,
    input coord_t y,
    input logic   de,
    input logic   hsync,
    input logic   fetch
);

    // R10: counters cleared one clock after enable is low
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !run |=> (x == '0 && y == '0));

    // R3: x steps by one inside the line
    p_x_step_r3: assert property (@(posedge clk) disable iff (rst)
        (run && x < h_total) |=> (x == $past(x) + 1'b1));

    // R3: x returns to zero at the end of the line
    p_x_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (run && x >= h_total) |=> (x == '0));

    // R4: data enable only inside the active window
    p_de_window_r4: assert property (@(posedge clk) disable iff (rst)
        de |-> (x <= h_act && y <= v_act));

    // R8: display-off blanks the video
    p_blank_r8: assert property (@(posedge clk) disable iff (rst)
        disp_off |-> !de);

    // R9: fetch strobe only at the programmed position
    p_fetch_pos_r9: assert property (@(posedge clk) disable iff (rst)
        fetch |-> (run && x == fetch_at));

    // R7: a silenced hsync rests at its inactive level
    p_hs_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (hs_off || all_off) |-> (hsync == hs_inv));

endmodule

bind raster_timing_gen rtg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (ctl.enable),
    .h_total  (cfg.h.total),
    .h_act    (cfg.h.active),
    .v_act    (cfg.v.active),
    .fetch_at (cfg.fetch_at),
    .hs_off   (sync_ctl.hs_off),
    .all_off  (sync_ctl.all_off),
    .hs_inv   (sync_ctl.hs_inv),
    .disp_off (disp_off),
    .x        (pix_x_o),
    .y        (pix_y_o),
    .de       (de_o),
    .hsync    (hsync_o),
    .fetch    (fetch_o)
);

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [11:0] x_o;
    logic [11:0] y_o;
    logic        de_o, hs_o, vs_o, pf_o, sov_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    raster_timing_gen u_dut (
        .clk          (clk),
        .rst          (rst),
        .reg_wr_en    (wr_en),
        .reg_wr_addr  (wr_addr),
        .reg_wr_data  (wr_data),
        .pix_x_o      (x_o),
        .pix_y_o      (y_o),
        .de_o         (de_o),
        .hsync_o      (hs_o),
        .vsync_o      (vs_o),
        .fetch_o      (pf_o),
        .sync_embed_o (sov_o)
    );

    typedef struct {
        int ht; int ha; int hsb; int hse;
        int vt; int va; int vsb; int vse;
        int fp; int sy; int dp; int ct;
    } mode_t;

    typedef struct {
        int x; int y;
        bit de; bit hs; bit vs; bit pf; bit sov;
        string t_pos; string t_de; string t_hs; string t_vs; string t_pf; string t_sov;
    } exp_t;

    exp_t sb_q[$];
    exp_t mon_e;

    // the reset mode of R2 in minus-one form
    mode_t m_def = '{1687, 1279, 1327, 1439, 1065, 1023, 1024, 1027, 1599, 0, 0, 3};

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic exp_t predict(mode_t m, int x, int y, bit run, string base);
        exp_t e;
        bit hw, vw, hg, vg;
        hw = (x > m.hsb) && (x <= m.hse);
        vw = (y > m.vsb) && (y <= m.vse);
        hg = run && hw && !m.sy[5] && !m.sy[1];
        vg = run && vw && !m.sy[6] && !m.sy[1];
        e.x   = x;
        e.y   = y;
        e.hs  = hg ^ m.sy[3];
        e.vs  = vg ^ m.sy[4];
        e.sov = m.sy[0] && (hg || vg);
        e.de  = run && m.ct[1] && !m.dp[1] && (x <= m.ha) && (y <= m.va);
        e.pf  = run && (x == m.fp);
        if (base != "") begin
            e.t_pos = base; e.t_de = base; e.t_hs = base;
            e.t_vs = base; e.t_pf = base; e.t_sov = base;
        end else begin
            e.t_pos = "R3";
            e.t_de  = m.dp[1] ? "R8" : (!m.ct[1] ? "R11" : "R4");
            e.t_hs  = (m.sy[5] || m.sy[1]) ? "R7" : (m.sy[3] ? "R6" : "R5");
            e.t_vs  = (m.sy[6] || m.sy[1]) ? "R7" : (m.sy[4] ? "R6" : "R5");
            e.t_pf  = "R9";
            e.t_sov = "R12";
        end
        return e;
    endfunction

    // monitor: one expected record per falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            mon_e = sb_q.pop_front();
            check(mon_e.t_pos, "x",      int'(x_o),   mon_e.x);
            check(mon_e.t_pos, "y",      int'(y_o),   mon_e.y);
            check(mon_e.t_de,  "de",     int'(de_o),  int'(mon_e.de));
            check(mon_e.t_hs,  "hsync",  int'(hs_o),  int'(mon_e.hs));
            check(mon_e.t_vs,  "vsync",  int'(vs_o),  int'(mon_e.vs));
            check(mon_e.t_pf,  "fetch",  int'(pf_o),  int'(mon_e.pf));
            check(mon_e.t_sov, "embed",  int'(sov_o), int'(mon_e.sov));
        end
    end

    // R13: one write per cycle, sampled at the next rising edge
    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = 12'(d);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(posedge clk);
        #1;
    endtask

    task automatic push_idle(mode_t m, int n, string tag);
        for (int i = 0; i < n; i++) sb_q.push_back(predict(m, 0, 0, 1'b0, tag));
    endtask

    task automatic push_run(mode_t m, int n, string base);
        int x = 0;
        int y = 0;
        for (int i = 0; i < n; i++) begin
            sb_q.push_back(predict(m, x, y, 1'b1, base));
            if (x == m.ht) begin
                x = 0;
                y = (y == m.vt) ? 0 : y + 1;
            end else begin
                x = x + 1;
            end
        end
    endtask

    task automatic load(mode_t m);
        wr(1, m.ht);  wr(2, m.ha);  wr(3, m.hsb); wr(4, m.hse);
        wr(5, m.vt);  wr(6, m.va);  wr(7, m.vsb); wr(8, m.vse);
        wr(9, m.fp);  wr(10, m.sy); wr(11, m.dp);
    endtask

    task automatic stop_and_idle(mode_t m);
        wr(0, 0);
        @(posedge clk);
        #1;
        push_idle(m, 4, "R10");
        drain();
    endtask

    task automatic run_mode(mode_t m);
        load(m);
        push_idle(m, 4, "R10");   // new polarity visible while disabled
        drain();
        wr(0, m.ct);              // R13: enable lands at this edge
        push_run(m, 2 * (m.ht + 1) * (m.vt + 1), "");
        drain();
        stop_and_idle(m);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: quiet reset state
        push_idle(m_def, 5, "R1");
        drain();
        // R2: reset timing runs one full line and a bit
        wr(0, 3);
        push_run(m_def, 1700, "R2");
        drain();
        stop_and_idle(m_def);
        // plain polarity, refresh on
        run_mode('{19, 9, 12, 15, 7, 3, 4, 5, 17, 'h00, 0, 3});
        // both syncs inverted, display off (R6, R8)
        run_mode('{15, 7, 9, 11, 5, 2, 3, 4, 3, 'h18, 2, 3});
        // hsync silenced, vsync inverted, fetch at x=0 (R7, R6, R9)
        run_mode('{23, 15, 17, 19, 9, 5, 6, 8, 0, 'h30, 0, 3});
        // embedded sync with vsync silenced, fetch at last pixel (R12)
        run_mode('{11, 5, 6, 8, 4, 1, 2, 3, 11, 'h41, 0, 3});
        // all syncs off with hsync inverted, refresh clear (R7, R11)
        run_mode('{13, 7, 8, 10, 4, 2, 3, 3, 5, 'h0A, 0, 1});
        finish_run();
    end

endmodule